// File: doc/BRIEF.md
# Cross-Domain Clock Frequency Counter

This block measures how fast an unknown test clock runs compared with a free-running reference clock. A sequencer in the reference domain repeats a fixed frame. First it clears a counter in the test domain. Next it opens a counting window of exactly 2^WIN_LOG2 reference cycles, then closes it and lets the test side go quiet. After that it asks the test side to copy the frozen count into a snapshot register, and finally it loads that snapshot into the result register. Every control that reaches the test domain is registered in the reference domain and passes through a multi-flop synchronizer clocked by the test clock.

The result is the number of test-clock rising edges in one window. It is therefore the frequency ratio scaled by the window length: with the default 4096-cycle window, a test clock ten times faster than the reference gives 40960. The result is 16 bits wide by default, stops at its maximum value instead of wrapping, and is announced with a one-cycle valid pulse. Each phase around the window lasts SETTLE reference cycles. Counting is correct as long as the test period is no longer than SETTLE/(SYNC_STAGES+2) reference periods (4 with the defaults).

Top module: `clk_freq_meter`

## Requirements
- R1: The count enable is held for exactly 2^WIN_LOG2 = 4096 reference cycles per frame. A test clock at an integer multiple k of the reference frequency gives a result of 4096*k (k = 10 gives 40960, k = 8 gives 32768).
- R2: A test clock slower than the reference is counted in proportion: a test period of twice the reference period gives 2048.
- R3: The result is CNT_W = 16 bits wide and saturates at 65535 instead of wrapping. A ratio of exactly 16 gives 65535, not 0, and a ratio of 20 gives 65535.
- R4: A frame lasts WIN + 3*SETTLE + 1 = 4145 reference cycles. meas_valid is high for one cycle after reference rising edge n (counted from the first edge with rst_n high) exactly when n is a positive multiple of 4145, and low after every other edge.
- R5: meas_count changes only together with a valid pulse and holds its value in every other cycle.
- R6: The test counter is cleared at the start of every frame, so windows are independent. The same ratio twice gives the same result, and a lower ratio after a saturated window gives the lower value.
- R7: Reset is active-low and synchronous to ref_clk. After an edge with rst_n low, meas_valid is 0 and meas_count is 0. The test-domain clear is asserted, the enable is off, and the frame restarts from its beginning when rst_n returns high.
- R8: The test counter changes only on test edges where the synchronized clear or the synchronized enable is active.
- R9: The reference domain loads the result only from the test-domain snapshot register, and only while the count enable is off on both sides and the snapshot has been stable for at least the last reference cycle.
- R10: The phases run in a fixed order: clear, count, drain, snapshot, load. The snapshot request never overlaps the enable or the clear, and the load always directly follows a snapshot cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; defines the window |
| tst_clk | input | 1 | Clock whose frequency is measured |
| rst_n | input | 1 | Active-low reset, synchronous to ref_clk |
| meas_count | output | CNT_W | Test edges counted in the last window, saturated |
| meas_valid | output | 1 | One reference-cycle pulse when meas_count is updated |

## Verification
The test clock is run at integer ratios of 10, 8, 16, 20 and one half of the reference frequency, with edges placed so that they never coincide with reference edges. This makes every expected count exact. Ratio 10 repeated twice shows that the counter is cleared between windows rather than accumulating. Ratio 16 lands exactly one past the largest 16-bit value, which separates saturation from wrapping to zero, and ratio 20 shows that the counter stays saturated well beyond the limit. The drop from a saturated window to ratio 8 proves the clear again, and the half-rate clock shows that a test clock slower than the reference still passes the synchronizers intact. A reset in the middle of a window checks the cleared outputs and the restart of the frame timing.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

   // Ordered phases of one measurement frame.
   typedef enum logic [2:0] {
      PH_CLEAR = 3'd0,
      PH_COUNT = 3'd1,
      PH_DRAIN = 3'd2,
      PH_SNAP  = 3'd3,
      PH_LOAD  = 3'd4
   } cfm_phase_e;

   // Registered control set produced in the reference domain.
   typedef struct packed {
      logic clr;
      logic en;
      logic snap;
      logic load;
   } cfm_ctl_t;

endpackage

// File: rtl/cfm_ref_seq.sv
module cfm_ref_seq
   import cfm_pkg::*;
#(
   parameter int WIN_LOG2 = 12,
   parameter int SETTLE   = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   output cfm_ctl_t ctl
);

   localparam int DW = WIN_LOG2 + 1;
   localparam int WIN = 1 << WIN_LOG2;
   localparam logic [DW-1:0] WIN_LAST = DW'(WIN - 1);
   localparam logic [DW-1:0] SET_LAST = DW'(SETTLE - 1);

   if (SETTLE < 4 || SETTLE > WIN) begin : g_bad_settle
      $error("cfm_ref_seq: SETTLE must lie in 4..2**WIN_LOG2");
   end

   cfm_phase_e    ph_q, ph_d;
   logic [DW-1:0] dw_q, dw_d;
   cfm_ctl_t      ctl_d;

   always_comb begin
      ph_d = ph_q;
      dw_d = dw_q + DW'(1);
      case (ph_q)
         PH_CLEAR: if (dw_q == SET_LAST) begin ph_d = PH_COUNT; dw_d = '0; end
         PH_COUNT: if (dw_q == WIN_LAST) begin ph_d = PH_DRAIN; dw_d = '0; end
         PH_DRAIN: if (dw_q == SET_LAST) begin ph_d = PH_SNAP;  dw_d = '0; end
         PH_SNAP:  if (dw_q == SET_LAST) begin ph_d = PH_LOAD;  dw_d = '0; end
         PH_LOAD:  begin ph_d = PH_CLEAR; dw_d = '0; end
         default:  begin ph_d = PH_CLEAR; dw_d = '0; end
      endcase
      // Controls are flops of their own so nothing glitchy crosses domains.
      ctl_d.clr  = (ph_d == PH_CLEAR);
      ctl_d.en   = (ph_d == PH_COUNT);
      ctl_d.snap = (ph_d == PH_SNAP);
      ctl_d.load = (ph_d == PH_LOAD);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= PH_CLEAR;
         dw_q <= '0;
         ctl  <= '{clr: 1'b1, en: 1'b0, snap: 1'b0, load: 1'b0};
      end else begin
         ph_q <= ph_d;
         dw_q <= dw_d;
         ctl  <= ctl_d;
      end
   end

endmodule

// File: rtl/cfm_sync.sv
module cfm_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] shreg;

   always_ff @(posedge clk) begin
      shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];

endmodule

// File: rtl/cfm_tst_count.sv
module cfm_tst_count #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             snap,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] hold
);

   logic [CNT_W-1:0] cnt_nx;

   if (SATURATE) begin : g_sat
      assign cnt_nx = (&cnt) ? cnt : cnt + CNT_W'(1);
   end else begin : g_wrap
      assign cnt_nx = cnt + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= cnt_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (snap) begin
         hold <= cnt;
      end
   end

endmodule

// File: rtl/cfm_capture.sv
module cfm_capture #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] snap_val,
   output logic [CNT_W-1:0] result,
   output logic             valid
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
         valid  <= 1'b0;
      end else begin
         valid <= load;
         if (load) begin
            result <= snap_val;
         end
      end
   end

endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
   import cfm_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int WIN_LOG2    = 12,
   parameter int SETTLE      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             ref_clk,
   input  logic             tst_clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] meas_count,
   output logic             meas_valid
);

   localparam int XW = 3;

   if (CNT_W < 2) begin : g_bad_width
      $error("clk_freq_meter: CNT_W must be at least 2");
   end
   if (SETTLE < 2 * SYNC_STAGES + 2) begin : g_bad_guard
      $error("clk_freq_meter: SETTLE too short for the synchronizer depth");
   end

   cfm_ctl_t         ctl;
   logic             ctl_clr, ctl_en, ctl_snap, ctl_load;
   logic [XW-1:0]    ctl_vec, syn_vec;
   logic             syn_clr, syn_en, syn_snap;
   logic [CNT_W-1:0] tst_cnt, tst_hold;

   cfm_ref_seq #(
      .WIN_LOG2 (WIN_LOG2),
      .SETTLE   (SETTLE)
   ) u_seq (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .ctl   (ctl)
   );

   assign ctl_clr  = ctl.clr;
   assign ctl_en   = ctl.en;
   assign ctl_snap = ctl.snap;
   assign ctl_load = ctl.load;
   assign ctl_vec  = {ctl_clr, ctl_en, ctl_snap};

   cfm_sync #(
      .STAGES (SYNC_STAGES),
      .W      (XW)
   ) u_sync (
      .clk (tst_clk),
      .d   (ctl_vec),
      .q   (syn_vec)
   );

   assign {syn_clr, syn_en, syn_snap} = syn_vec;

   cfm_tst_count #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_tcnt (
      .clk  (tst_clk),
      .clr  (syn_clr),
      .en   (syn_en),
      .snap (syn_snap),
      .cnt  (tst_cnt),
      .hold (tst_hold)
   );

   cfm_capture #(
      .CNT_W (CNT_W)
   ) u_cap (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .load     (ctl_load),
      .snap_val (tst_hold),
      .result   (meas_count),
      .valid    (meas_valid)
   );

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
   parameter int CNT_W    = 16,
   parameter int WIN_LOG2 = 12,
   parameter bit SATURATE = 1'b1
) (
   input logic             ref_clk,
   input logic             tst_clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] meas_count,
   input logic             meas_valid,
   input logic             ctl_clr,
   input logic             ctl_en,
   input logic             ctl_snap,
   input logic             ctl_load,
   input logic             syn_clr,
   input logic             syn_en,
   input logic [CNT_W-1:0] tst_cnt,
   input logic [CNT_W-1:0] tst_hold
);

   localparam int RW = WIN_LOG2 + 1;
   localparam logic [RW-1:0] WIN_V = RW'(1 << WIN_LOG2);

   logic [RW-1:0] en_run;

   always_ff @(posedge ref_clk) begin
      if (!rst_n)      en_run <= '0;
      else if (ctl_en) en_run <= en_run + RW'(1);
      else             en_run <= '0;
   end

   // R1: enable stays on for exactly one window length
   a_r1_window_len: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(ctl_en) |-> en_run == WIN_V);

   // R4: one-cycle valid that follows the load phase
   a_r4_valid_after_load: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ctl_load |=> meas_valid);
   a_r4_valid_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
      meas_valid |=> !meas_valid);

   // R5: result holds between pulses
   a_r5_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !meas_valid |-> $stable(meas_count));

   // R7: reset state
   a_r7_reset_state: assert property (@(posedge ref_clk)
      !rst_n |=> (!meas_valid && meas_count == '0 && ctl_clr && !ctl_en));

   // R8: counter frozen unless synchronized clear or enable
   a_r8_frozen: assert property (@(posedge tst_clk) disable iff (!rst_n)
      (!syn_en && !syn_clr) |=> $stable(tst_cnt));

   // R9: snapshot settled and counting stopped when loaded
   a_r9_load_stable: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ctl_load |-> ($stable(tst_hold) && !ctl_en && !syn_en));

   // R10: phase ordering
   a_r10_snap_alone: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ctl_snap |-> (!ctl_en && !ctl_clr));
   a_r10_load_after_snap: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ctl_load |-> $past(ctl_snap));

   if (SATURATE) begin : g_sat_chk
      // R3: a full counter stays full until cleared
      a_r3_saturate: assert property (@(posedge tst_clk) disable iff (!rst_n)
         (&tst_cnt && !syn_clr) |=> &tst_cnt);
   end

endmodule

bind clk_freq_meter cfm_checker #(
   .CNT_W    (CNT_W),
   .WIN_LOG2 (WIN_LOG2),
   .SATURATE (SATURATE)
) u_chk (
   .ref_clk    (ref_clk),
   .tst_clk    (tst_clk),
   .rst_n      (rst_n),
   .meas_count (meas_count),
   .meas_valid (meas_valid),
   .ctl_clr    (ctl_clr),
   .ctl_en     (ctl_en),
   .ctl_snap   (ctl_snap),
   .ctl_load   (ctl_load),
   .syn_clr    (syn_clr),
   .syn_en     (syn_en),
   .tst_cnt    (tst_cnt),
   .tst_hold   (tst_hold)
);

// File: tb/sim_clk_freq_meter.sv
module sim_clk_freq_meter;

   localparam int WIN    = 4096;
   localparam int SETTLE = 16;
   localparam int FRAME  = WIN + 3 * SETTLE + 1;
   localparam int REF_PS = 4000;
   localparam int MAXC   = 65535;
   localparam int WDOG   = 150000;

   logic        rclk = 1'b0;
   logic        tclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tclk_run = 1'b0;
   int          half_ps = 200;
   logic [15:0] meas_count;
   logic        meas_valid;

   int    checks = 0;
   int    errors = 0;
   int    edges = 0;
   int    cyc = 0;
   logic  rst_smp = 1'b0;
   logic  started = 1'b0;
   int    last_cnt = 0;
   int    exp_cnt = 0;
   int    skip = 0;
   string exp_tag = "R1";

   clk_freq_meter u0 (
      .ref_clk    (rclk),
      .tst_clk    (tclk),
      .rst_n      (rst_n),
      .meas_count (meas_count),
      .meas_valid (meas_valid)
   );

   always #2ns rclk = ~rclk;

   // Test clock: parks low when stopped, restarts 50 ps after a request so
   // its edges never coincide with reference edges.
   initial begin
      forever begin
         if (!tclk_run) begin
            tclk = 1'b0;
            wait (tclk_run);
            #50ps;
         end
         #(half_ps * 1ps);
         tclk = ~tclk;
      end
   end

   function automatic int expect_for(int h);
      int v;
      v = (WIN * REF_PS) / (2 * h);
      return (v > MAXC) ? MAXC : v;
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge rclk) begin
      cyc++;
      started = 1'b1;
      rst_smp = rst_n;
      if (rst_n) edges++;
      else       edges = 0;
      if (cyc > WDOG) begin
         chk(1'b0, "watchdog", cyc, WDOG);
         finish_run();
      end
   end

   // Behavioural reference model, compared every reference cycle.
   always @(negedge rclk) begin
      if (started) begin
         if (!rst_smp) begin
            chk(meas_valid == 1'b0, "R7 valid in reset", int'(meas_valid), 0);
            chk(meas_count == 16'd0, "R7 count in reset", int'(meas_count), 0);
            last_cnt = 0;
         end else begin
            automatic bit exp_v = (edges >= FRAME) && (edges % FRAME == 0);
            chk(meas_valid == exp_v, "R4 R10 valid timing", int'(meas_valid), int'(exp_v));
            if (!meas_valid) begin
               chk(int'(meas_count) == last_cnt, "R5 hold", int'(meas_count), last_cnt);
            end else if (skip > 0) begin
               skip--;
            end else begin
               chk(int'(meas_count) == exp_cnt, {exp_tag, " R8 R9 count"},
                   int'(meas_count), exp_cnt);
            end
            last_cnt = int'(meas_count);
         end
      end
   end

   task automatic wait_valid(int k);
      for (int i = 0; i < k; i++) begin
         do @(negedge rclk); while (!meas_valid);
      end
   endtask

   // Change the test clock in the middle of a window; that result is discarded.
   task automatic set_ratio(int h, string tag);
      repeat (1000) @(negedge rclk);
      tclk_run = 1'b0;
      repeat (4) @(negedge rclk);
      half_ps = h;
      exp_cnt = expect_for(h);
      exp_tag = tag;
      skip    = 1;
      tclk_run = 1'b1;
   endtask

   initial begin
      half_ps  = 200;
      exp_cnt  = expect_for(200);   // R1: ratio 10 -> 40960
      exp_tag  = "R1";
      tclk_run = 1'b1;
      rst_n    = 1'b0;
      repeat (4) @(negedge rclk);
      rst_n = 1'b1;
      wait_valid(1);
      exp_tag = "R6 repeat";        // same ratio again, no accumulation
      wait_valid(1);
      set_ratio(125, "R3 exact limit");
      wait_valid(2);
      set_ratio(100, "R3 above limit");
      wait_valid(2);
      set_ratio(250, "R6 R1 after saturation");
      wait_valid(2);
      set_ratio(4000, "R2 slow");
      wait_valid(2);
      // R7: reset in the middle of a window, then a clean frame
      repeat (500) @(negedge rclk);
      rst_n = 1'b0;
      repeat (3) @(negedge rclk);
      rst_n = 1'b1;
      exp_tag = "R7 after reset";
      wait_valid(1);
      repeat (5) @(negedge rclk);
      finish_run();
   end

endmodule